// File: doc/BRIEF.md
# Static-Schedule Bus Arbitration Sequencer

This block hands a single shared bus to one pair of processing elements at a time, following a fixed transfer schedule worked out before run time. There are four processing elements (PE1 to PE4). Each non-idle state of the sequencer stands for exactly one transfer, with a known source PE and a known destination PE. A state is left only when the granted source offers data and the granted destination accepts it in the same cycle. The schedule has no round-robin or priority logic.

Two boolean values that cross the bus decide how the schedule runs. The first is the iteration-start flag, taken while idle from PE2. The second is the branch flag, carried by transfer 3. The arbiter snoops the bus data as these transfers complete and keeps its own copies. If the start flag is false, the iteration is empty. If the branch flag is false, a group of three transfers is skipped. No transfer runs twice in one iteration, so a destination that has already received a value uses its buffered copy.

The schedule is: 1 PE2→PE1, 2 PE2→PE3, 3 PE1→PE2 (branch flag), 4 PE3→PE2, 5 PE2→PE4, 6 PE1→PE4, 7 PE2→PE4, 8 PE4→PE2, 9 PE2→PE1, 10 PE2→PE3.

Top module: `sched_bus_arbiter`

## Requirements
- R1: Reset is synchronous and active high. Out of reset, the block is idle: `src_grant` is 4'b0010 (PE2, bit k = PE k+1), `dst_grant` is 0 and `done` is 0.
- R2: In idle, the start flag is bit 0 of `snoop_data`, sampled when `src_valid[1]` is high. If the bit is 0, the block stays idle and `done` is high for exactly the next cycle.
- R3: In idle, a sampled start bit of 1 moves the block to transfer 1 on the next cycle. Transfer 1 grants source PE2 and destination PE1.
- R4: Transfers 1 to 6 always run in schedule order, with the source and destination listed above.
- R5: The branch flag is bit 0 of `snoop_data` at the handshake of transfer 3. If it is 1, transfers 7, 8 and 9 follow transfer 6, and transfer 10 follows them.
- R6: If the branch flag is 0, transfer 10 directly follows transfer 6.
- R7: A transfer completes only when `src_valid` of its source and `dst_ready` of its destination are both high in the same cycle. Otherwise both grant vectors hold.
- R8: `src_grant` always has exactly one bit set. `dst_grant` has exactly one bit set in a transfer state and is zero in idle.
- R9: After the handshake of transfer 10, the block returns to idle and `done` is high for exactly one cycle.
- R10: An iteration completes 10 transfers when both flags are 1, 7 transfers when only the start flag is 1, and 0 transfers when the start flag is 0. No transfer is repeated.
- R11: Reset asserted in the middle of an iteration returns the block to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_PE | Per-PE source has data |
| dst_ready | input | N_PE | Per-PE destination can accept |
| snoop_data | input | DATA_W | Bus data seen by the arbiter |
| src_grant | output | N_PE | One-hot source grant |
| dst_grant | output | N_PE | One-hot destination grant, zero in idle |
| done | output | 1 | One-cycle pulse at the end of an iteration |

## Verification
Two events can fall in the same cycle. The end-of-iteration `done` pulse coincides with the idle state, and idle already offers the bus to PE2 for the next start flag. The bench keeps `src_valid` high through the final transfer of each iteration, so the next start sample lands in the very cycle that `done` is high. It then checks that `done` lasts one cycle and that the following iteration takes its own path. All four combinations of the two flags are swept, with and without stalls from the source and the destination. Every grant is compared against the schedule, and the number of transfers per iteration is counted.

// File: rtl/sba_pkg.sv
package sba_pkg;
   localparam int PE_CNT      = 4;
   localparam int PE_IDX_W    = 2;
   localparam int LAST_STEP   = 10;
   localparam int BRANCH_STEP = 6;
   localparam int HEAD_PE     = 1;

   typedef enum logic [1:0] {CAP_NONE, CAP_HEAD, CAP_BRANCH} cap_e;

   typedef struct packed {
      logic [PE_IDX_W-1:0] src;
      logic [PE_IDX_W-1:0] dst;
      cap_e                cap;
   } xfer_t;

   function automatic xfer_t mk(int s, int d, cap_e c);
      xfer_t x;
      x.src = PE_IDX_W'(s);
      x.dst = PE_IDX_W'(d);
      x.cap = c;
      return x;
   endfunction

   // PE index k is PE k+1
   function automatic xfer_t xfer_of(int step);
      case (step)
         1:       return mk(1, 0, CAP_NONE);
         2:       return mk(1, 2, CAP_NONE);
         3:       return mk(0, 1, CAP_BRANCH);
         4:       return mk(2, 1, CAP_NONE);
         5:       return mk(1, 3, CAP_NONE);
         6:       return mk(0, 3, CAP_NONE);
         7:       return mk(1, 3, CAP_NONE);
         8:       return mk(3, 1, CAP_NONE);
         9:       return mk(1, 0, CAP_NONE);
         10:      return mk(1, 2, CAP_NONE);
         default: return mk(HEAD_PE, 0, CAP_HEAD);
      endcase
   endfunction
endpackage

// File: rtl/sba_sched_rom.sv
module sba_sched_rom
   import sba_pkg::*;
#(
   parameter int STEP_W = 4
)(
   input  logic [STEP_W-1:0]   step,
   output logic [PE_IDX_W-1:0] src_idx,
   output logic [PE_IDX_W-1:0] dst_idx,
   output cap_e                cap
);
   localparam int DEPTH = 2**STEP_W;

   xfer_t tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      assign tbl[i] = xfer_of(i);
   end

   xfer_t cur;
   assign cur     = tbl[step];
   assign src_idx = cur.src;
   assign dst_idx = cur.dst;
   assign cap     = cur.cap;
endmodule

// File: rtl/sba_flag_latch.sv
module sba_flag_latch (
   input  logic clk,
   input  logic rst,
   input  logic cap_head,
   input  logic cap_branch,
   input  logic flag_in,
   output logic head_q,
   output logic branch_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         head_q   <= 1'b0;
         branch_q <= 1'b0;
      end else begin
         if (cap_head)   head_q   <= flag_in;
         if (cap_branch) branch_q <= flag_in;
      end
   end
endmodule

// File: rtl/sba_onehot_dec.sv
module sba_onehot_dec #(
   parameter int N = 4,
   parameter int W = 2
)(
   input  logic         en,
   input  logic [W-1:0] idx,
   output logic [N-1:0] onehot
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign onehot[i] = en && (idx == W'(i));
   end
endmodule

// File: rtl/sched_bus_arbiter.sv
module sched_bus_arbiter
   import sba_pkg::*;
#(
   parameter int N_PE     = 4,
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [N_PE-1:0]   src_valid,
   input  logic [N_PE-1:0]   dst_ready,
   input  logic [DATA_W-1:0] snoop_data,
   output logic [N_PE-1:0]   src_grant,
   output logic [N_PE-1:0]   dst_grant,
   output logic              done
);
   localparam int STEP_W = $clog2(LAST_STEP + 1);
   localparam logic [STEP_W-1:0] S_IDLE   = '0;
   localparam logic [STEP_W-1:0] S_FIRST  = STEP_W'(1);
   localparam logic [STEP_W-1:0] S_LAST   = STEP_W'(LAST_STEP);
   localparam logic [STEP_W-1:0] S_BRANCH = STEP_W'(BRANCH_STEP);

   if (N_PE != PE_CNT) begin : g_bad_pe
      $error("schedule is built for a fixed PE count");
   end
   if (FLAG_BIT >= DATA_W) begin : g_bad_flag
      $error("flag bit outside data word");
   end

   logic [STEP_W-1:0]   state_q, state_d;
   logic                done_d;
   logic [PE_IDX_W-1:0] cur_src, cur_dst;
   cap_e                cur_cap;
   logic                head_q, branch_q;
   logic                is_idle, flag_bit, hs;

   sba_sched_rom #(.STEP_W(STEP_W)) u_rom (
      .step    (state_q),
      .src_idx (cur_src),
      .dst_idx (cur_dst),
      .cap     (cur_cap)
   );

   assign is_idle  = (state_q == S_IDLE);
   assign flag_bit = snoop_data[FLAG_BIT];
   assign hs = is_idle ? src_valid[cur_src]
                       : (head_q & src_valid[cur_src] & dst_ready[cur_dst]);

   sba_flag_latch u_flags (
      .clk        (clk),
      .rst        (rst),
      .cap_head   (hs && cur_cap == CAP_HEAD),
      .cap_branch (hs && cur_cap == CAP_BRANCH),
      .flag_in    (flag_bit),
      .head_q     (head_q),
      .branch_q   (branch_q)
   );

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      if (hs) begin
         if (is_idle) begin
            if (flag_bit) state_d = S_FIRST;
            else          done_d  = 1'b1;
         end else if (state_q == S_LAST) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
         end else if (state_q == S_BRANCH && !branch_q) begin
            state_d = S_LAST;
         end else begin
            state_d = state_q + STEP_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= S_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= done_d;
      end
   end

   sba_onehot_dec #(.N(N_PE), .W(PE_IDX_W)) u_src_dec (
      .en (1'b1), .idx (cur_src), .onehot (src_grant)
   );
   sba_onehot_dec #(.N(N_PE), .W(PE_IDX_W)) u_dst_dec (
      .en (!is_idle), .idx (cur_dst), .onehot (dst_grant)
   );
endmodule

// File: rtl/sched_bus_arbiter_chk.sv
module sched_bus_arbiter_chk #(
   parameter int N_PE   = 4,
   parameter int DATA_W = 8,
   parameter int STEP_W = 4
)(
   input logic              clk,
   input logic              rst,
   input logic [N_PE-1:0]   src_valid,
   input logic [N_PE-1:0]   dst_ready,
   input logic [DATA_W-1:0] snoop_data,
   input logic [N_PE-1:0]   src_grant,
   input logic [N_PE-1:0]   dst_grant,
   input logic              done,
   input logic [STEP_W-1:0] state_q,
   input logic              branch_q
);
   logic idle_c, hs_c;
   assign idle_c = (state_q == '0);
   assign hs_c   = (|(src_valid & src_grant)) &&
                   (idle_c || (|(dst_ready & dst_grant)));

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (src_grant == N_PE'(2) && dst_grant == '0 && !done));

   p_empty_iter_r2: assert property (@(posedge clk) disable iff (rst)
      (idle_c && src_valid[1] && !snoop_data[0]) |=> (done && state_q == '0));

   p_start_r3: assert property (@(posedge clk) disable iff (rst)
      (idle_c && src_valid[1] && snoop_data[0]) |=> (state_q == STEP_W'(1)));

   p_skip_r6: assert property (@(posedge clk) disable iff (rst)
      (state_q == STEP_W'(6) && hs_c && !branch_q) |=> (state_q == STEP_W'(10)));

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!idle_c && !hs_c) |=> ($stable(src_grant) && $stable(dst_grant)));

   p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $countones(src_grant) == 1 && (idle_c ? dst_grant == '0 : $countones(dst_grant) == 1));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> idle_c);
endmodule

bind sched_bus_arbiter sched_bus_arbiter_chk #(
   .N_PE(N_PE), .DATA_W(DATA_W), .STEP_W(STEP_W)
) u_chk (
   .clk(clk), .rst(rst), .src_valid(src_valid), .dst_ready(dst_ready),
   .snoop_data(snoop_data), .src_grant(src_grant), .dst_grant(dst_grant),
   .done(done), .state_q(state_q), .branch_q(branch_q)
);

// File: tb/sim_sched_bus_arbiter.sv
module sim_sched_bus_arbiter;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] src_valid = '0;
   logic [3:0] dst_ready = '0;
   logic [7:0] snoop_data = '0;
   logic [3:0] src_grant, dst_grant;
   logic       done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   sched_bus_arbiter u0 (
      .clk(clk), .rst(rst), .src_valid(src_valid), .dst_ready(dst_ready),
      .snoop_data(snoop_data), .src_grant(src_grant), .dst_grant(dst_grant),
      .done(done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int exp_src(int s);
      case (s)
         3, 6: return 0;
         4:    return 2;
         8:    return 3;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_dst(int s);
      case (s)
         1, 9:    return 0;
         3, 4, 8: return 1;
         2, 10:   return 2;
         default: return 3;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_idle(string req);
      chk(req, {28'd0, src_grant}, 32'h2);
      chk(req, {28'd0, dst_grant}, 32'h0);
   endtask

   // one iteration; entered at a negedge with the block idle
   task automatic run_iter(bit h, bit a, bit stall);
      int n = 0;
      chk_idle("R2 idle grants");
      src_valid  = 4'hF;
      dst_ready  = 4'hF;
      snoop_data = {7'h2A, h};
      tick();
      if (!h) begin
         chk("R2 empty done", {31'd0, done}, 32'd1);
         chk_idle("R2 stays idle");
      end else begin
         chk("R3 no done", {31'd0, done}, 32'd0);
         for (int s = 1; s <= 10; s++) begin
            if (s == 7 && !a) s = 10;
            chk($sformatf("R4 R5 R6 src step %0d", s), {28'd0, src_grant}, 32'd1 << exp_src(s));
            chk($sformatf("R4 R5 R6 dst step %0d", s), {28'd0, dst_grant}, 32'd1 << exp_dst(s));
            if (stall) begin
               src_valid = ~(4'd1 << exp_src(s));
               dst_ready = 4'hF;
               tick();
               chk("R7 src stall", {28'd0, src_grant}, 32'd1 << exp_src(s));
               src_valid = 4'hF;
               dst_ready = ~(4'd1 << exp_dst(s));
               tick();
               chk("R7 dst stall", {28'd0, dst_grant}, 32'd1 << exp_dst(s));
               dst_ready = 4'hF;
            end
            snoop_data = (s == 3) ? {7'h15, a} : {7'h33, ~a};
            tick();
            n++;
            if (s != 10) chk("R9 no early done", {31'd0, done}, 32'd0);
         end
         chk("R9 done pulse", {31'd0, done}, 32'd1);
         chk_idle("R9 back to idle");
      end
      chk($sformatf("R10 count h=%0d a=%0d", h, a), n, h ? (a ? 10 : 7) : 0);
   endtask

   initial begin
      tick();
      tick();
      rst = 1'b0;
      chk_idle("R1 reset grants");
      chk("R1 reset done", {31'd0, done}, 32'd0);
      // sweep of flags and stalls; iterations run back to back
      for (int st = 0; st < 2; st++)
         for (int h = 0; h < 2; h++)
            for (int a = 0; a < 2; a++)
               run_iter(h[0], a[0], st[0]);
      // done cycle followed at once by another sample
      run_iter(1'b1, 1'b0, 1'b0);
      chk("R9 single pulse", {31'd0, done}, 32'd1);
      run_iter(1'b0, 1'b1, 1'b0);
      // reset in mid-iteration
      src_valid  = 4'hF;
      dst_ready  = 4'hF;
      snoop_data = 8'h01;
      tick();
      tick();
      tick();
      chk("R11 mid state", {28'd0, src_grant}, 32'd1 << exp_src(3));
      rst = 1'b1;
      tick();
      rst = 1'b0;
      src_valid = '0;
      chk_idle("R11 reset to idle");
      chk("R11 done low", {31'd0, done}, 32'd0);
      tick();
      chk_idle("R1 holds idle without valid");
      run_iter(1'b1, 1'b1, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule